// File: doc/BRIEF.md
# Flag-Branching Microcode Sequencer

This block is the control half of a microcoded processor. Each cycle it forms the address of the next control word from three parts: the current instruction code, a micro-step count, and one condition bit taken from the processor status byte. It reads that word from an internal control store and breaks it into the bus-control fields that steer the datapath. The datapath registers and the ALU sit outside the block. The instruction code and the status byte arrive as inputs.

The condition bit is chosen by a three-bit selector in the current word. The selector can also pick a compound "positive and non-zero" condition. A negate bit inverts the whole status byte before the selection is made. Certain field codes stop the machine. When one appears, the sequencer freezes and holds a halt-reason code until reset. Other field codes ask the datapath to add the selected constant to the program counter.

The control store is written through a load port. The port works only while reset is held, so the microprogram is in place before the first step.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is held, the step count is 0xF, the current control word is all zeros, the halt reason is 0 and no program-counter increment is requested.
- R2: On each clock edge that is not frozen, the step count becomes 0 if bit 7 of the current word is set. Otherwise it increments modulo 16, so 15 wraps to 0. The store is read at {instruction, condition bit, new step}, with the step in the low bits and the condition bit directly above it. The word read and its address appear one cycle later.
- R3: The condition bit is chosen by word bits 3:1, taken from the status byte: 0 selects bit 7 (sign), 1 selects bit 6 (carry), 2 selects bit 5 (overflow), 3 selects bit 4 (zero), and 4 selects "sign and zero both clear". Codes 5, 6 and 7 give 0.
- R4: When word bit 0 is set, the status byte is inverted before the selection, and this includes the compound condition.
- R5: The fields of the current word are output as follows: address source from bits 31:28, data source from bits 27:24, write target from bits 23:20, left source from bits 19:16, right source from bits 15:12, and ALU function from bits 11:8.
- R6: Bits 6:4 select the constant output from this table, indexed 0 to 7: 0x0000, 0x0001, 0xFFFF, 0x0005, 0x0004, 0x0003, 0x0002, 0xFFFE.
- R7: The halt reason is encoded as 2 for data source 14 (invalid state), 3 for data source 15 (invalid instruction), 1 for write target 15 (normal stop), and 0 otherwise. A data-source code wins over the write-target code.
- R8: Once the halt reason is non-zero, the step count, the address and the word stay fixed until reset, whatever the instruction and status inputs do.
- R9: A program-counter increment is requested when the address field is 15, the left field is 11, the right field is 10, the ALU field is 12, or the condition selector is 7. No request is raised while halted.
- R10: A load-port write takes effect only while reset is held. A write with reset released leaves the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | INSTR_W | Current instruction code |
| status_i | input | 8 | Status byte (sign 7, carry 6, overflow 5, zero 4) |
| load_en_i | input | 1 | Store write strobe (honoured only in reset) |
| load_addr_i | input | ADDR_W | Store write address |
| load_data_i | input | 32 | Store write data |
| rom_addr_o | output | ADDR_W | Address of the current word |
| step_o | output | STEP_W | Current step count |
| ctrl_word_o | output | 32 | Current control word |
| addr_src_o | output | 4 | Address-bus source field |
| data_src_o | output | 4 | Data-bus source field |
| data_wr_o | output | 4 | Data-bus write target field |
| left_src_o | output | 4 | Left-operand source field |
| right_src_o | output | 4 | Right-operand source field |
| alu_fn_o | output | 4 | ALU function field |
| const_o | output | CONST_W | Selected constant, sign-extended |
| pc_inc_o | output | 1 | Program-counter increment request |
| halt_reason_o | output | 2 | Sticky halt reason |

## Verification
The hardest case to reach from the ports is the condition bit under each selector, negated or not. That bit only shows up a cycle after the word that selects it, as one bit of the next store address. To reach it, the bench loads a small program per instruction code. Step 0 holds the selector under test. Step 1 holds two different marker words at the two condition-bit addresses. Reading which marker arrives, and at what address, exposes the chosen bit. A halt is then entered while the instruction and status inputs keep changing, to show the freeze.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef struct packed {
      logic [3:0] addr_src;
      logic [3:0] data_src;
      logic [3:0] data_wr;
      logic [3:0] left_src;
      logic [3:0] right_src;
      logic [3:0] alu_fn;
      logic       step_clr;
      logic [2:0] const_sel;
      logic [2:0] flag_sel;
      logic       negate;
   } ctl_word_t;

   typedef enum logic [1:0] {
      HALT_NONE      = 2'd0,
      HALT_STOP      = 2'd1,
      HALT_BAD_STATE = 2'd2,
      HALT_BAD_INSTR = 2'd3
   } halt_t;

   localparam logic [3:0] SRC_BAD_STATE = 4'd14;
   localparam logic [3:0] SRC_BAD_INSTR = 4'd15;
   localparam logic [3:0] WR_STOP       = 4'd15;
   localparam logic [3:0] INC_ADDR      = 4'd15;
   localparam logic [3:0] INC_LEFT      = 4'd11;
   localparam logic [3:0] INC_RIGHT     = 4'd10;
   localparam logic [3:0] INC_ALU       = 4'd12;
   localparam logic [2:0] INC_FLAG      = 3'd7;

   localparam int BIT_SIGN  = 7;
   localparam int BIT_CARRY = 6;
   localparam int BIT_OVF   = 5;
   localparam int BIT_ZERO  = 4;

   function automatic logic [15:0] const_lookup(input logic [2:0] sel);
      case (sel)
         3'd0:    return 16'h0000;
         3'd1:    return 16'h0001;
         3'd2:    return 16'hFFFF;
         3'd3:    return 16'h0005;
         3'd4:    return 16'h0004;
         3'd5:    return 16'h0003;
         3'd6:    return 16'h0002;
         default: return 16'hFFFE;
      endcase
   endfunction

endpackage

// File: rtl/useq_flag_pick.sv
module useq_flag_pick
   import useq_pkg::*;
(
   input  logic [7:0] status_i,
   input  logic [2:0] sel_i,
   input  logic       negate_i,
   output logic       flag_o
);
   logic s_bit, c_bit, v_bit, z_bit;

   always_comb begin
      s_bit = status_i[BIT_SIGN]  ^ negate_i;
      c_bit = status_i[BIT_CARRY] ^ negate_i;
      v_bit = status_i[BIT_OVF]   ^ negate_i;
      z_bit = status_i[BIT_ZERO]  ^ negate_i;
      case (sel_i)
         3'd0:    flag_o = s_bit;
         3'd1:    flag_o = c_bit;
         3'd2:    flag_o = v_bit;
         3'd3:    flag_o = z_bit;
         3'd4:    flag_o = ~s_bit & ~z_bit;
         default: flag_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/useq_field_decode.sv
module useq_field_decode
   import useq_pkg::*;
#(
   parameter int CONST_W = 16
)(
   input  ctl_word_t          cw_i,
   output halt_t              halt_o,
   output logic               inc_req_o,
   output logic [CONST_W-1:0] const_o
);
   logic [15:0] base_const;

   always_comb begin
      if (cw_i.data_src == SRC_BAD_STATE)
         halt_o = HALT_BAD_STATE;
      else if (cw_i.data_src == SRC_BAD_INSTR)
         halt_o = HALT_BAD_INSTR;
      else if (cw_i.data_wr == WR_STOP)
         halt_o = HALT_STOP;
      else
         halt_o = HALT_NONE;

      inc_req_o = (cw_i.addr_src  == INC_ADDR)  ||
                  (cw_i.left_src  == INC_LEFT)  ||
                  (cw_i.right_src == INC_RIGHT) ||
                  (cw_i.alu_fn    == INC_ALU)   ||
                  (cw_i.flag_sel  == INC_FLAG);
      base_const = const_lookup(cw_i.const_sel);
   end

   generate
      if (CONST_W == 16) begin : g_exact
         assign const_o = base_const;
      end else begin : g_sext
         assign const_o = {{(CONST_W-16){base_const[15]}}, base_const};
      end
   endgenerate
endmodule

// File: rtl/useq_store.sv
module useq_store #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= mem[rd_addr_i];
   end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
   import useq_pkg::*;
#(
   parameter int INSTR_W = 6,
   parameter int STEP_W  = 4,
   parameter int CONST_W = 16,
   localparam int ADDR_W = INSTR_W + 1 + STEP_W,
   localparam int CW_W   = $bits(ctl_word_t)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [7:0]         status_i,
   input  logic               load_en_i,
   input  logic [ADDR_W-1:0]  load_addr_i,
   input  logic [CW_W-1:0]    load_data_i,
   output logic [ADDR_W-1:0]  rom_addr_o,
   output logic [STEP_W-1:0]  step_o,
   output logic [CW_W-1:0]    ctrl_word_o,
   output logic [3:0]         addr_src_o,
   output logic [3:0]         data_src_o,
   output logic [3:0]         data_wr_o,
   output logic [3:0]         left_src_o,
   output logic [3:0]         right_src_o,
   output logic [3:0]         alu_fn_o,
   output logic [CONST_W-1:0] const_o,
   output logic               pc_inc_o,
   output logic [1:0]         halt_reason_o
);
   generate
      if (INSTR_W < 1 || INSTR_W > 8) begin : g_bad_instr_w
         $error("INSTR_W must lie in 1..8");
      end
      if (STEP_W < 1 || STEP_W > 6) begin : g_bad_step_w
         $error("STEP_W must lie in 1..6");
      end
      if (CONST_W < 16) begin : g_bad_const_w
         $error("CONST_W must be at least 16");
      end
   endgenerate

   logic [CW_W-1:0]   cw_raw;
   ctl_word_t         cw;
   halt_t             halt;
   logic              halted;
   logic              flag_bit;
   logic              inc_req;
   logic [STEP_W-1:0] step_q, step_nxt;
   logic [ADDR_W-1:0] addr_q, addr_nxt;

   assign cw     = ctl_word_t'(cw_raw);
   assign halted = (halt != HALT_NONE);

   useq_flag_pick u_flag (
      .status_i (status_i),
      .sel_i    (cw.flag_sel),
      .negate_i (cw.negate),
      .flag_o   (flag_bit)
   );

   useq_field_decode #(.CONST_W(CONST_W)) u_dec (
      .cw_i      (cw),
      .halt_o    (halt),
      .inc_req_o (inc_req),
      .const_o   (const_o)
   );

   assign step_nxt = cw.step_clr ? '0 : step_q + 1'b1;
   assign addr_nxt = {instr_i, flag_bit, step_nxt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '1;
         addr_q <= '0;
      end else if (!halted) begin
         step_q <= step_nxt;
         addr_q <= addr_nxt;
      end
   end

   useq_store #(.ADDR_W(ADDR_W), .DATA_W(CW_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (load_en_i & ~rst_n),
      .wr_addr_i (load_addr_i),
      .wr_data_i (load_data_i),
      .rd_en_i   (~halted),
      .rd_addr_i (addr_nxt),
      .rd_data_o (cw_raw)
   );

   assign rom_addr_o    = addr_q;
   assign step_o        = step_q;
   assign ctrl_word_o   = cw_raw;
   assign addr_src_o    = cw.addr_src;
   assign data_src_o    = cw.data_src;
   assign data_wr_o     = cw.data_wr;
   assign left_src_o    = cw.left_src;
   assign right_src_o   = cw.right_src;
   assign alu_fn_o      = cw.alu_fn;
   assign pc_inc_o      = inc_req & ~halted;
   assign halt_reason_o = halt;

   // R2: a set clear bit brings the step back to zero on the next edge
   assert_step_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && cw.step_clr) |=> (step_q == '0));

   // R2: otherwise the step advances by one, wrapping at the top
   assert_step_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && !cw.step_clr) |=> (step_q == STEP_W'($past(step_q) + 1'b1)));

   // R3: forced-low selector codes leave a zero condition bit in the next address
   assert_forced_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && cw.flag_sel >= 3'd5) |=> (rom_addr_o[STEP_W] == 1'b0));

   // R8: a halted sequencer keeps step, address and word
   assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> ($stable(step_q) && $stable(addr_q) && $stable(cw_raw)));

   // R8: the reason code does not change once set
   assert_reason_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halt_reason_o == $past(halt_reason_o)));

   // R9: no increment request during a halt
   assert_inc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_reason_o != 2'd0) |-> !pc_inc_o);

endmodule

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
   localparam int IW = 6;
   localparam int SW = 4;
   localparam int AW = IW + 1 + SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] instr_i = '0;
   logic [7:0]    status_i = '0;
   logic          load_en_i = 1'b0;
   logic [AW-1:0] load_addr_i = '0;
   logic [31:0]   load_data_i = '0;
   logic [AW-1:0] rom_addr_o;
   logic [SW-1:0] step_o;
   logic [31:0]   ctrl_word_o;
   logic [3:0]    addr_src_o, data_src_o, data_wr_o, left_src_o, right_src_o, alu_fn_o;
   logic [15:0]   const_o;
   logic          pc_inc_o;
   logic [1:0]    halt_reason_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   useq_sequencer #(.INSTR_W(IW), .STEP_W(SW), .CONST_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .status_i(status_i),
      .load_en_i(load_en_i), .load_addr_i(load_addr_i), .load_data_i(load_data_i),
      .rom_addr_o(rom_addr_o), .step_o(step_o), .ctrl_word_o(ctrl_word_o),
      .addr_src_o(addr_src_o), .data_src_o(data_src_o), .data_wr_o(data_wr_o),
      .left_src_o(left_src_o), .right_src_o(right_src_o), .alu_fn_o(alu_fn_o),
      .const_o(const_o), .pc_inc_o(pc_inc_o), .halt_reason_o(halt_reason_o)
   );

   // {selector[3], negate, status[8], expected condition bit}
   localparam logic [12:0] VEC [12] = '{
      {3'd0, 1'b0, 8'h80, 1'b1},
      {3'd1, 1'b0, 8'h40, 1'b1},
      {3'd2, 1'b0, 8'hDF, 1'b0},
      {3'd3, 1'b0, 8'h10, 1'b1},
      {3'd4, 1'b0, 8'h00, 1'b1},
      {3'd4, 1'b0, 8'h10, 1'b0},
      {3'd4, 1'b1, 8'h90, 1'b1},
      {3'd3, 1'b1, 8'h10, 1'b0},
      {3'd5, 1'b1, 8'hFF, 1'b0},
      {3'd6, 1'b0, 8'hFF, 1'b0},
      {3'd7, 1'b1, 8'h00, 1'b0},
      {3'd1, 1'b1, 8'h00, 1'b1}
   };

   function automatic logic [15:0] ctab(input int k);
      case (k)
         0: return 16'h0000; 1: return 16'h0001; 2: return 16'hFFFF; 3: return 16'h0005;
         4: return 16'h0004; 5: return 16'h0003; 6: return 16'h0002; default: return 16'hFFFE;
      endcase
   endfunction

   function automatic logic [31:0] img(input int a);
      int i, f, s;
      i = a >> 5; f = (a >> 4) & 1; s = a & 15;
      if (i < 12) begin
         if (s == 0) return {28'd0, VEC[i][12:10], VEC[i][9]};
         if (s == 1) return (f == 1) ? 32'h180 : 32'h280;
         return 32'h80;
      end
      if (i == 12) return 32'(s & 7) << 4;
      if (i == 13) return (s == 0) ? (32'd14 << 24) : 32'h80;
      if (i == 14) return (s == 0) ? ((32'd15 << 24) | (32'd15 << 20)) : 32'h80;
      if (i == 15) return (s == 0) ? ((32'd15 << 20) | (32'd15 << 28)) : 32'h80;
      if (i == 16) begin
         case (s)
            0: return (32'd15 << 28) | 32'h30;
            1: return (32'd11 << 16) | 32'h30;
            2: return (32'd10 << 12) | 32'h30;
            3: return (32'd12 << 8)  | 32'h30;
            4: return (32'd7 << 1)   | 32'h30;
            default: return 32'hB0;
         endcase
      end
      return 32'h80;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic restart(input int ins, input logic [7:0] st);
      rst_n = 1'b0; instr_i = IW'(ins); status_i = st;
      tick();
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1;
      // load the store while reset is held
      for (int a = 0; a < (1 << AW); a++) begin
         load_en_i = 1'b1; load_addr_i = AW'(a); load_data_i = img(a);
         tick();
      end
      load_en_i = 1'b0;

      // R1 reset state
      chk(step_o == 4'hF, "R1", "step in reset", step_o, 4'hF);
      chk(ctrl_word_o == 32'h0, "R1", "word in reset", ctrl_word_o, 0);
      chk(halt_reason_o == 2'd0, "R1", "halt in reset", halt_reason_o, 0);
      chk(pc_inc_o == 1'b0, "R1", "inc in reset", pc_inc_o, 0);

      // condition-bit vectors (R3, R4), step clear (R2)
      for (int i = 0; i < 12; i++) begin
         logic [7:0] st;
         logic       ex;
         st = VEC[i][8:1]; ex = VEC[i][0];
         restart(i, st);
         tick();
         chk(rom_addr_o == AW'(i*32 + int'(st[7])*16), "R2", "first address",
             rom_addr_o, i*32 + int'(st[7])*16);
         tick();
         chk(rom_addr_o == AW'(i*32 + int'(ex)*16 + 1), VEC[i][9] ? "R4" : "R3",
             "condition address", rom_addr_o, i*32 + int'(ex)*16 + 1);
         chk(ctrl_word_o == (ex ? 32'h180 : 32'h280), VEC[i][9] ? "R4" : "R3",
             "marker word", ctrl_word_o, ex ? 32'h180 : 32'h280);
         if (i == 0) begin
            tick();
            chk(step_o == 4'd0, "R2", "step clear", step_o, 0);
         end
      end

      // step walk with wrap and constant table (R2, R6)
      restart(12, 8'h00);
      for (int k = 1; k <= 17; k++) begin
         tick();
         chk(step_o == SW'((k-1) % 16), "R2", "step walk", step_o, (k-1) % 16);
         chk(const_o == ctab((k-1) % 8), "R6", "constant", const_o, ctab((k-1) % 8));
      end

      // invalid-state halt and freeze (R7, R8)
      restart(13, 8'h00);
      tick();
      chk(halt_reason_o == 2'd2, "R7", "invalid state reason", halt_reason_o, 2);
      instr_i = 6'd3; status_i = 8'hFF;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk(step_o == 4'd0 && rom_addr_o == AW'(416), "R8", "frozen address",
             rom_addr_o, 416);
         chk(halt_reason_o == 2'd2, "R8", "sticky reason", halt_reason_o, 2);
      end

      // priority and field decode on halt (R7, R5)
      restart(14, 8'h00);
      tick();
      chk(halt_reason_o == 2'd3, "R7", "invalid instr wins", halt_reason_o, 3);
      chk(data_src_o == 4'd15 && data_wr_o == 4'd15, "R5", "data fields",
          {data_src_o, data_wr_o}, 8'hFF);

      // normal stop suppresses increment (R7, R9, R5)
      restart(15, 8'h00);
      tick();
      chk(halt_reason_o == 2'd1, "R7", "normal stop", halt_reason_o, 1);
      chk(pc_inc_o == 1'b0, "R9", "no inc while halted", pc_inc_o, 0);
      chk(addr_src_o == 4'd15, "R5", "address field", addr_src_o, 15);

      // increment request sources (R9, R5, R6)
      restart(16, 8'h00);
      for (int k = 0; k < 5; k++) begin
         tick();
         chk(pc_inc_o == 1'b1, "R9", "inc request", pc_inc_o, 1);
         chk(const_o == 16'h0005, "R6", "inc amount", const_o, 5);
         if (k == 1) chk(left_src_o == 4'd11, "R5", "left field", left_src_o, 11);
         if (k == 2) chk(right_src_o == 4'd10, "R5", "right field", right_src_o, 10);
         if (k == 3) chk(alu_fn_o == 4'd12, "R5", "alu field", alu_fn_o, 12);
      end
      tick();
      chk(pc_inc_o == 1'b0 && step_o == 4'd5, "R9", "no request", pc_inc_o, 0);

      // load outside reset is ignored (R10)
      load_en_i = 1'b1; load_addr_i = AW'(17*32); load_data_i = 32'h0000_0F00;
      tick();
      load_en_i = 1'b0;
      restart(17, 8'h00);
      tick();
      chk(ctrl_word_o == 32'h80, "R10", "store unchanged", ctrl_word_o, 32'h80);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule